// File: doc/BRIEF.md
# Serial-Entry Program Store Controller

This block puts a small on-chip program store into a programming or read-back state. After the reset line has been held high for a minimum number of clocks, the following ten samples of the same line form a mode code, least significant bit first. That code picks one of four targets: the 2K-byte user array, the 16-byte key table, security flag 1, or security flag 2. A logic-level voltage-select input then picks between writing and reading back within the chosen target.

An 11-bit address arrives on an 8-bit port. While the address-select input is high, the port carries the top three address bits. When address-select falls, those bits are held, and the port then carries the low byte. Writes are counted as bursts of active-low strobes. A write can only clear bits, so it ANDs the data into the cell. User bytes are read back XNOR-combined with the key byte picked by the four lowest address bits. Two sticky security flags limit further writes and read-back.

Top module: `eprom_prog_ctrl`

## Requirements
- R1: After `resetLine` has been high on at least RST_HOLD (24) rising clock edges, the next ten edges sample `resetLine` as a code, bit 0 first. Code 296H selects the user array, 292H the key table, 29AH security flag 1 with security read-back, and 298H security flag 2.
- R2: An unrecognised code, or a high phase shorter than RST_HOLD, leaves the block idle with `dataOe` low. Strobes have no effect in that state, and only a new long high phase on `resetLine` leaves it.
- R3: Outside code reception, `resetLine` high drops any active mode, and `dataOe` is low from the following edge.
- R4: While `addrSel` is high, `addrPort[2:0]` supplies address bits 10:8. These bits keep their value after `addrSel` falls, and `addrPort` then supplies bits 7:0.
- R5: The address counts as stable once `addrSel` has been low and `addrPort` unchanged for SETTLE (13) clocks.
- R6: With `vpp` low in an active mode, `dataOe` is high. `verifyValid` and non-zero `dataOut` appear only after VERIFY_DELAY (48) edges in that state with a stable address. Before that, `dataOut` is 00H.
- R7: With `vpp` high in an active mode, the PULSES-th (25th) rising edge of `pgmN` writes `cell & dataIn` into the addressed cell. A shorter burst followed by `vpp` low writes nothing.
- R8: User read-back returns NOT(user byte XOR key byte[addr[3:0]]). An erased key byte (FFH) passes the user byte unchanged. All cells read FFH after power-on clear.
- R9: Key read-back returns key byte addr[3:0] unmodified.
- R10: With security flag 1 set, writes to the user array and key table are ignored, and key read-back returns 00H. User read-back still works.
- R11: With security flag 2 set, both user and key read-back return 00H with `verifyValid` high.
- R12: Security read-back (code 29AH, `vpp` low) returns bit 7 = flag 1 and bit 6 = flag 2, each 1 when set, with all other bits 0. Both flags are sticky until power-on clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all sampling on its rising edge |
| porN | input | 1 | Power-on clear, active low: erases arrays and flags |
| resetLine | input | 1 | Reset level, and serial mode code after a long high |
| vpp | input | 1 | 1 = write, 0 = read-back within the active mode |
| pgmN | input | 1 | Active-low write strobe |
| addrSel | input | 1 | 1 = port carries high address bits |
| addrPort | input | 8 | Multiplexed address |
| dataIn | input | 8 | Byte to write |
| dataOut | output | 8 | Read-back byte |
| dataOe | output | 1 | Data port drive enable |
| verifyValid | output | 1 | Read-back byte is valid |

## Verification
On every cycle, the assertions check several properties. The security flags never clear, and no write strobe reaches the arrays while flag 1 is set. No user or key read-back is selected while flag 2 is set. A write can only clear bits. A write strobe always coincides with a rising `pgmN` edge while `vpp` is high. The output is released after the reset line rises.

Only the bench scenarios can show the rest. These are the exact decoding of each code, the 48-clock read-back boundary, and the encrypted values across every key position. They also cover the 24-versus-25 strobe boundary and the ignored writes after the security flags are set.

// File: rtl/epc_pkg.sv
package epc_pkg;

  typedef enum logic [2:0] {
    MODE_NONE,
    MODE_USER,
    MODE_KEY,
    MODE_SEC1,
    MODE_SEC2
  } mode_e;

  typedef enum logic [2:0] {
    RD_NONE,
    RD_USER,
    RD_KEY,
    RD_SEC,
    RD_BLOCK
  } rdsel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic   writeUser;
    logic   writeKey;
    logic   setSec1;
    logic   setSec2;
    rdsel_e rdSel;
    logic   driveOut;
    logic   readValid;
  } dp_strobe_t;

  localparam logic [9:0] CODE_USER = 10'h296;
  localparam logic [9:0] CODE_KEY  = 10'h292;
  localparam logic [9:0] CODE_SEC1 = 10'h29A;
  localparam logic [9:0] CODE_SEC2 = 10'h298;

  function automatic mode_e decodeCode(input logic [9:0] code);
    mode_e m;
    case (code)
      CODE_USER: m = MODE_USER;
      CODE_KEY:  m = MODE_KEY;
      CODE_SEC1: m = MODE_SEC1;
      CODE_SEC2: m = MODE_SEC2;
      default:   m = MODE_NONE;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/epc_ctrl.sv
module epc_ctrl
  import epc_pkg::*;
#(
  parameter int RST_HOLD     = 24,
  parameter int PULSES       = 25,
  parameter int VERIFY_DELAY = 48
) (
  input  logic       clk,
  input  logic       porN,
  input  logic       resetLine,
  input  logic       vpp,
  input  logic       pgmN,
  input  logic       addrStable,
  input  logic       sec1,
  input  logic       sec2,
  output dp_strobe_t strb
);

  localparam int HOLD_W  = $clog2(RST_HOLD + 1);
  localparam int PULSE_W = $clog2(PULSES);
  localparam int VER_W   = $clog2(VERIFY_DELAY + 1);

  typedef enum logic [1:0] {ST_IDLE, ST_HOLD, ST_SHIFT, ST_ACTIVE} state_e;

  state_e               state;
  mode_e                mode;
  logic [HOLD_W-1:0]    holdCnt;
  logic [9:0]           shiftReg;
  logic [3:0]           bitCnt;
  logic [PULSE_W-1:0]   pulseCnt;
  logic [VER_W-1:0]     verCnt;
  logic                 pgmPrev;

  logic [9:0] nextCode;
  logic       active, pgmRise, fire, verifying;

  assign nextCode  = {resetLine, shiftReg[9:1]};
  assign active    = (state == ST_ACTIVE);
  assign pgmRise   = pgmN & ~pgmPrev;
  assign fire      = active & vpp & pgmRise & (pulseCnt == PULSE_W'(PULSES - 1));
  assign verifying = active & ~vpp;

  // mode entry sequencer
  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      state    <= ST_IDLE;
      mode     <= MODE_NONE;
      holdCnt  <= '0;
      shiftReg <= '0;
      bitCnt   <= '0;
    end else if (state == ST_SHIFT) begin
      shiftReg <= nextCode;
      if (bitCnt == 4'd9) begin
        mode  <= decodeCode(nextCode);
        state <= (decodeCode(nextCode) != MODE_NONE) ? ST_ACTIVE : ST_IDLE;
      end else begin
        bitCnt <= bitCnt + 4'd1;
      end
    end else if (resetLine) begin
      mode  <= MODE_NONE;
      state <= ST_HOLD;
      if (state != ST_HOLD)
        holdCnt <= HOLD_W'(1);
      else if (holdCnt < HOLD_W'(RST_HOLD))
        holdCnt <= holdCnt + HOLD_W'(1);
    end else if (state == ST_HOLD) begin
      if (holdCnt >= HOLD_W'(RST_HOLD)) begin
        shiftReg <= nextCode;
        bitCnt   <= 4'd1;
        state    <= ST_SHIFT;
      end else begin
        state <= ST_IDLE;
      end
    end
  end

  // strobe counter and read-back timer
  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      pulseCnt <= '0;
      verCnt   <= '0;
      pgmPrev  <= 1'b1;
    end else begin
      pgmPrev <= pgmN;
      if (active && vpp) begin
        if (pgmRise)
          pulseCnt <= fire ? '0 : pulseCnt + PULSE_W'(1);
      end else begin
        pulseCnt <= '0;
      end
      if (verifying) begin
        if (verCnt < VER_W'(VERIFY_DELAY))
          verCnt <= verCnt + VER_W'(1);
      end else begin
        verCnt <= '0;
      end
    end
  end

  always_comb begin
    strb           = '0;
    strb.rdSel     = RD_NONE;
    strb.writeUser = fire & (mode == MODE_USER) & ~sec1;
    strb.writeKey  = fire & (mode == MODE_KEY) & ~sec1;
    strb.setSec1   = fire & (mode == MODE_SEC1);
    strb.setSec2   = fire & (mode == MODE_SEC2);
    strb.driveOut  = verifying;
    strb.readValid = verifying & (verCnt == VER_W'(VERIFY_DELAY)) & addrStable;
    if (verifying) begin
      case (mode)
        MODE_USER: strb.rdSel = sec2 ? RD_BLOCK : RD_USER;
        MODE_KEY:  strb.rdSel = (sec1 | sec2) ? RD_BLOCK : RD_KEY;
        MODE_SEC1,
        MODE_SEC2: strb.rdSel = RD_SEC;
        default:   strb.rdSel = RD_NONE;
      endcase
    end
  end

  a_r3_reset_releases_port: assert property (@(posedge clk) disable iff (!porN)
    (resetLine && state != ST_SHIFT) |=> !strb.driveOut);

  a_r7_write_on_strobe_rise: assert property (@(posedge clk) disable iff (!porN)
    (strb.writeUser || strb.writeKey || strb.setSec1 || strb.setSec2)
      |-> (pgmN && !$past(pgmN) && vpp));

  a_r6_valid_only_in_readback: assert property (@(posedge clk) disable iff (!porN)
    $rose(strb.readValid) |-> (!vpp && !$past(vpp)));

endmodule

// File: rtl/epc_datapath.sv
module epc_datapath
  import epc_pkg::*;
#(
  parameter int ADDR_W    = 11,
  parameter int KEY_DEPTH = 16,
  parameter int SETTLE    = 13
) (
  input  logic       clk,
  input  logic       porN,
  input  logic       addrSel,
  input  logic [7:0] addrPort,
  input  logic [7:0] dataIn,
  input  dp_strobe_t strb,
  output logic       addrStable,
  output logic       sec1,
  output logic       sec2,
  output logic [7:0] dataOut,
  output logic       dataOe,
  output logic       readValid
);

  localparam int HI_W   = ADDR_W - 8;
  localparam int KEY_AW = $clog2(KEY_DEPTH);
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int ST_W   = $clog2(SETTLE + 1);

  logic [HI_W-1:0]   highAddr;
  logic [7:0]        lowAddr;
  logic [ST_W-1:0]   stableCnt;
  logic [ADDR_W-1:0] wrAddr;
  logic [KEY_AW-1:0] keyIdx;

  logic [7:0] userMem [DEPTH];
  logic [7:0] keyMem  [KEY_DEPTH];
  logic [7:0] userByte, keyByte, rdData;

  assign wrAddr     = {highAddr, lowAddr};
  assign keyIdx     = wrAddr[KEY_AW-1:0];
  assign addrStable = (stableCnt == ST_W'(SETTLE));
  assign userByte   = userMem[wrAddr];
  assign keyByte    = keyMem[keyIdx];

  // multiplexed address capture
  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      highAddr  <= '0;
      lowAddr   <= '0;
      stableCnt <= '0;
    end else if (addrSel) begin
      highAddr  <= addrPort[HI_W-1:0];
      stableCnt <= '0;
    end else begin
      lowAddr <= addrPort;
      if (addrPort != lowAddr)
        stableCnt <= '0;
      else if (stableCnt < ST_W'(SETTLE))
        stableCnt <= stableCnt + ST_W'(1);
    end
  end

  // user array: writes only clear bits
  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      for (int i = 0; i < DEPTH; i++) userMem[i] <= 8'hFF;
    end else if (strb.writeUser) begin
      userMem[wrAddr] <= userByte & dataIn;
    end
  end

  // key table, one cell per entry
  for (genvar k = 0; k < KEY_DEPTH; k++) begin : g_key
    always_ff @(posedge clk or negedge porN) begin
      if (!porN)
        keyMem[k] <= 8'hFF;
      else if (strb.writeKey && keyIdx == KEY_AW'(k))
        keyMem[k] <= keyMem[k] & dataIn;
    end
  end

  // sticky security flags
  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      sec1 <= 1'b0;
      sec2 <= 1'b0;
    end else begin
      if (strb.setSec1) sec1 <= 1'b1;
      if (strb.setSec2) sec2 <= 1'b1;
    end
  end

  always_comb begin
    case (strb.rdSel)
      RD_USER: rdData = ~(userByte ^ keyByte);
      RD_KEY:  rdData = keyByte;
      RD_SEC:  rdData = {sec1, sec2, 6'b0};
      default: rdData = 8'h00;
    endcase
  end

  assign dataOut   = strb.readValid ? rdData : 8'h00;
  assign dataOe    = strb.driveOut;
  assign readValid = strb.readValid;

  a_r10_sec1_blocks_writes: assert property (@(posedge clk) disable iff (!porN)
    sec1 |-> !(strb.writeUser || strb.writeKey));

  a_r11_sec2_blocks_reads: assert property (@(posedge clk) disable iff (!porN)
    sec2 |-> (strb.rdSel != RD_USER && strb.rdSel != RD_KEY));

  a_r12_sec1_sticky: assert property (@(posedge clk) disable iff (!porN)
    sec1 |=> sec1);

  a_r12_sec2_sticky: assert property (@(posedge clk) disable iff (!porN)
    sec2 |=> sec2);

  a_r7_write_clears_only: assert property (@(posedge clk) disable iff (!porN)
    strb.writeUser |=> ((userMem[$past(wrAddr)] & ~$past(userByte)) == 8'h00));

  a_r5_stable_after_low: assert property (@(posedge clk) disable iff (!porN)
    addrStable |-> !$past(addrSel));

endmodule

// File: rtl/eprom_prog_ctrl.sv
module eprom_prog_ctrl
  import epc_pkg::*;
#(
  parameter int ADDR_W       = 11,
  parameter int KEY_DEPTH    = 16,
  parameter int SETTLE       = 13,
  parameter int RST_HOLD     = 24,
  parameter int PULSES       = 25,
  parameter int VERIFY_DELAY = 48
) (
  input  logic       clk,
  input  logic       porN,
  input  logic       resetLine,
  input  logic       vpp,
  input  logic       pgmN,
  input  logic       addrSel,
  input  logic [7:0] addrPort,
  input  logic [7:0] dataIn,
  output logic [7:0] dataOut,
  output logic       dataOe,
  output logic       verifyValid
);

  dp_strobe_t strb;
  logic       addrStable, sec1, sec2;

  epc_ctrl #(
    .RST_HOLD    (RST_HOLD),
    .PULSES      (PULSES),
    .VERIFY_DELAY(VERIFY_DELAY)
  ) u_ctrl (
    .clk       (clk),
    .porN      (porN),
    .resetLine (resetLine),
    .vpp       (vpp),
    .pgmN      (pgmN),
    .addrStable(addrStable),
    .sec1      (sec1),
    .sec2      (sec2),
    .strb      (strb)
  );

  epc_datapath #(
    .ADDR_W   (ADDR_W),
    .KEY_DEPTH(KEY_DEPTH),
    .SETTLE   (SETTLE)
  ) u_dp (
    .clk       (clk),
    .porN      (porN),
    .addrSel   (addrSel),
    .addrPort  (addrPort),
    .dataIn    (dataIn),
    .strb      (strb),
    .addrStable(addrStable),
    .sec1      (sec1),
    .sec2      (sec2),
    .dataOut   (dataOut),
    .dataOe    (dataOe),
    .readValid (verifyValid)
  );

endmodule

// File: tb/eprom_prog_ctrl_test.sv
module eprom_prog_ctrl_test;

  logic       clk = 1'b0;
  logic       porN = 1'b0;
  logic       resetLine = 1'b0;
  logic       vpp = 1'b0;
  logic       pgmN = 1'b1;
  logic       addrSel = 1'b0;
  logic [7:0] addrPort = 8'h00;
  logic [7:0] dataIn = 8'hFF;
  logic [7:0] dataOut;
  logic       dataOe, verifyValid;

  int  checks = 0;
  int  failures = 0;
  bit  done = 1'b0;

  logic [7:0] expU [2048];
  logic [7:0] expK [16];

  always #2.5 clk = ~clk;

  eprom_prog_ctrl uut (
    .clk(clk), .porN(porN), .resetLine(resetLine), .vpp(vpp), .pgmN(pgmN),
    .addrSel(addrSel), .addrPort(addrPort), .dataIn(dataIn),
    .dataOut(dataOut), .dataOe(dataOe), .verifyValid(verifyValid)
  );

  task automatic chk(input string req, input logic [8:0] act, input logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic enterMode(input logic [9:0] code, input int hold);
    @(negedge clk) resetLine = 1'b1;
    repeat (hold) @(negedge clk);
    for (int i = 0; i < 10; i++) begin
      resetLine = code[i];
      @(negedge clk);
    end
    resetLine = 1'b0;
  endtask

  task automatic setAddr(input logic [10:0] a);
    @(negedge clk);
    addrSel  = 1'b1;
    addrPort = {5'b0, a[10:8]};
    repeat (14) @(negedge clk);
    addrSel = 1'b0;
    repeat (2) @(negedge clk);
    addrPort = a[7:0];
    repeat (16) @(negedge clk);
  endtask

  task automatic progByte(input logic [10:0] a, input logic [7:0] d, input int n);
    setAddr(a);
    dataIn = d;
    vpp = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk) pgmN = 1'b0;
      @(negedge clk) pgmN = 1'b1;
    end
    @(negedge clk) vpp = 1'b0;
  endtask

  task automatic readAt(input logic [10:0] a, input string req, input logic [7:0] exp);
    setAddr(a);
    repeat (50) @(negedge clk);
    chk(req, {verifyValid, dataOut}, {1'b1, exp});
  endtask

  function automatic logic [7:0] enc(input logic [10:0] a);
    return ~(expU[a] ^ expK[a[3:0]]);
  endfunction

  initial begin
    logic [10:0] a0;
    for (int i = 0; i < 2048; i++) expU[i] = 8'hFF;
    for (int i = 0; i < 16; i++) expK[i] = 8'hFF;

    repeat (5) @(negedge clk);
    porN = 1'b1;
    @(negedge clk);
    chk("R8 reset port idle", {verifyValid, dataOe, 7'b0}, 9'h0);

    // short high phase: no mode
    enterMode(10'h296, 5);
    repeat (3) @(negedge clk);
    chk("R2 short hold idle", {8'b0, dataOe}, 9'h0);

    // unknown code: idle, strobes ignored
    enterMode(10'h294, 30);
    repeat (3) @(negedge clk);
    chk("R2 bad code idle", {8'b0, dataOe}, 9'h0);
    progByte(11'h010, 8'h00, 25);
    chk("R2 bad code port off", {8'b0, dataOe}, 9'h0);

    // key table writes, entry 15 stays erased
    enterMode(10'h292, 30);
    chk("R1 key mode drives", {8'b0, dataOe}, 9'h1);
    for (int i = 0; i < 15; i++) begin
      logic [7:0] kv;
      kv = 8'h5A ^ 8'(i * 23);
      progByte(11'(i), kv, 25);
      expK[i] = kv;
    end
    for (int i = 0; i < 16; i++) readAt(11'(i), "R9 key readback", expK[i]);

    // read-back latency boundary
    setAddr(11'h005);
    enterMode(10'h292, 30);
    repeat (47) @(negedge clk);
    chk("R6 before delay", {verifyValid, dataOut}, {1'b0, 8'h00});
    chk("R6 drive during wait", {8'b0, dataOe}, 9'h1);
    @(negedge clk);
    chk("R6 at delay", {verifyValid, dataOut}, {1'b1, expK[5]});

    // user array sweep
    enterMode(10'h296, 30);
    for (int i = 0; i < 40; i++) begin
      logic [10:0] a;
      logic [7:0]  d;
      a = 11'((i * 53 + 7) & 11'h7FF);
      d = 8'(i * 29) ^ 8'hA5;
      progByte(a, d, 25);
      expU[a] = expU[a] & d;
    end
    a0 = 11'd7;
    progByte(a0, 8'h0F, 25);
    expU[a0] = expU[a0] & 8'h0F;
    progByte(11'h123, 8'h00, 24);
    for (int i = 0; i < 40; i++) begin
      logic [10:0] a;
      a = 11'((i * 53 + 7) & 11'h7FF);
      readAt(a, "R8 user encrypted", enc(a));
    end
    readAt(a0, "R7 write ANDs", enc(a0));
    readAt(11'h123, "R7 short burst no write", enc(11'h123));
    readAt(11'h010, "R2 ignored strobes", enc(11'h010));
    readAt(11'd431, "R8 erased key passthrough", expU[431]);
    chk("R4 high bits used", {1'b0, expU[431]}, {1'b0, 8'(8'hA5 ^ 8'(8 * 29))});

    // reset line drops the mode
    @(negedge clk) resetLine = 1'b1;
    @(negedge clk);
    chk("R3 reset drops mode", {8'b0, dataOe}, 9'h0);
    resetLine = 1'b0;
    repeat (3) @(negedge clk);
    chk("R3 stays idle", {8'b0, dataOe}, 9'h0);

    // security flags
    enterMode(10'h29A, 30);
    readAt(11'h000, "R12 flags clear", 8'h00);
    progByte(11'h000, 8'h00, 25);
    readAt(11'h000, "R12 flag1 set", 8'h80);
    enterMode(10'h292, 30);
    progByte(11'h003, 8'h00, 25);
    readAt(11'h003, "R10 key readback blocked", 8'h00);
    enterMode(10'h296, 30);
    progByte(a0, 8'h00, 25);
    readAt(a0, "R10 user write blocked", enc(a0));
    readAt(11'h7F3, "R10 key write blocked", expK[3]);
    enterMode(10'h298, 30);
    progByte(11'h000, 8'h00, 25);
    enterMode(10'h29A, 30);
    readAt(11'h000, "R12 both flags", 8'hC0);
    enterMode(10'h296, 30);
    readAt(a0, "R11 user readback blocked", 8'h00);
    enterMode(10'h292, 30);
    readAt(11'h004, "R11 key readback blocked", 8'h00);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule